// File: doc/BRIEF.md
# Two-Phase Modular Checksum Accumulator

This block keeps an 18-bit checksum state in two registers, `x` and `y`. Each data word it accepts takes two clock cycles to fold into the state, and one adder is shared between the two cycles. In the first cycle the adder adds the word to `x` and parks the sum and its carry. In the second cycle the same adder adds the fixed reduction constant 2^18 − 254225 = 7919 to the parked sum. A carry from either cycle shows that the sum reached the modulus. The reduced value is then written back; otherwise the unreduced sum is kept. The new value goes into `y` and the old `y` moves into `x`, so each result becomes an operand of a later step.

The upstream source presents a word with `valid_i`, and the word is taken only while `busy_o` is low. `busy_o` is high for the single reduction cycle. A comparator with no subtractor watches every value written back. It chains AND stages (for one bits of the modulus) and OR stages (for zero bits) from the LSB upward. It raises a sticky error flag as soon as a stored value is at or above 254225, which can only happen when a word at or above the modulus is fed in.

Top module: `mchk_accum`

## Requirements
- R1: While `rst_ni` is low, `x_o`, `y_o`, `busy_o` and `err_o` are all 0.
- R2: A word is accepted on a rising edge where `valid_i` is 1 and `busy_o` is 0. `busy_o` is then 1 for exactly the next cycle.
- R3: `valid_i` and `data_i` on an edge where `busy_o` is 1 have no effect on the state.
- R4: At the edge that ends the busy cycle, `x_o` takes the old `y_o`. `y_o` takes s = x + d if that is below 254225, otherwise s − 254225, where x is the `x_o` value at acceptance and d is the accepted word. Only one modulus is ever removed.
- R5: When x + d is at least 2^18, the result is still x + d − 254225.
- R6: A sum exactly equal to 254225 stores 0, and a sum of 254224 stores 254224.
- R7: `err_o` becomes 1 on the same edge that writes a `y_o` value of 254225 or more.
- R8: Once set, `err_o` stays 1 until reset.
- R9: `err_o` stays 0 while every written value is below 254225, including 254224.
- R10: With `busy_o` low and `valid_i` low, `x_o` and `y_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Data word present |
| data_i | input | 18 | Data word to accumulate |
| busy_o | output | 1 | Reduction phase in progress; no word taken |
| x_o | output | 18 | Older state register |
| y_o | output | 18 | Newer state register |
| err_o | output | 1 | Sticky flag: a stored value reached the modulus |

## Verification
The write-back of a reduced result and the rise of the error flag fall on the same clock edge. The bench therefore checks `y_o` and `err_o` together in the cycle after the busy cycle. To provoke this, it first steers `x_o` to 254224 and then feeds words of 254225 and 254226. These give stored values of exactly 254224, where the flag must stay low, and 254225, where it must rise. A word of 2^18 − 1 then gives a value well past the modulus, which checks the flag in a wrapped case. A separate scenario holds `valid_i` high through the busy cycle with a different word, and requires that only the first word reaches the state.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

  typedef enum logic {
    PH_ADD = 1'b0,
    PH_RED = 1'b1
  } phase_e;

endpackage

// File: rtl/mchk_adder.sv
module mchk_adder #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);

  always_comb begin
    {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
  end

endmodule

// File: rtl/mchk_ge_detect.sv
// val_i >= MOD by a bit-serial AND/OR chain: a one bit of MOD needs the bit set
// and the lower part >= ; a zero bit passes if the bit is set or the lower part >=.
module mchk_ge_detect #(
  parameter int unsigned W   = 18,
  parameter int unsigned MOD = 254225
) (
  input  logic [W-1:0] val_i,
  output logic         ge_o
);

  localparam logic [W-1:0] MOD_V = W'(MOD);

  logic [W:0] chain;
  assign chain[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_seg
    if (MOD_V[i]) begin : g_one
      assign chain[i+1] = val_i[i] & chain[i];
    end else begin : g_zero
      assign chain[i+1] = val_i[i] | chain[i];
    end
  end

  assign ge_o = chain[W];

endmodule

// File: rtl/mchk_phase.sv
module mchk_phase
  import mchk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic accept_o,
  output logic red_o
);

  phase_e ph_q;

  assign accept_o = valid_i && (ph_q == PH_ADD);
  assign red_o    = (ph_q == PH_RED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_ADD;
    else if (accept_o) ph_q <= PH_RED;
    else if (red_o) ph_q <= PH_ADD;
  end

  assert_red_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_o |=> !red_o);
  assert_accept_to_red_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> red_o);

endmodule

// File: rtl/mchk_accum.sv
module mchk_accum #(
  parameter int unsigned W   = 18,
  parameter int unsigned MOD = 254225
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         err_o
);

  localparam logic [W-1:0] MOD_V = W'(MOD);
  localparam logic [W-1:0] RED_K = ~MOD_V + 1'b1;  // 2^W - MOD

  logic         accept, red;
  logic [W-1:0] x_q, y_q, s_q;
  logic         c0_q, err_q;
  logic [W-1:0] op_a, op_b, sum, res;
  logic [W-1:0] gate;
  logic         cy, wrap, res_ge;

  mchk_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .accept_o(accept),
    .red_o   (red)
  );

  // phase selects operands: data word in phase 0, constant in phase 1
  assign gate = {W{red}};
  assign op_a = red ? s_q : x_q;
  assign op_b = (data_i & ~gate) | (RED_K & gate);

  mchk_adder #(.W(W)) u_add (
    .a_i    (op_a),
    .b_i    (op_b),
    .sum_o  (sum),
    .carry_o(cy)
  );

  // carry from either phase means the sum reached MOD
  assign wrap = c0_q | cy;
  assign res  = wrap ? sum : s_q;

  mchk_ge_detect #(.W(W), .MOD(MOD)) u_ge (
    .val_i(res),
    .ge_o (res_ge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q  <= '0;
      c0_q <= 1'b0;
    end else if (accept) begin
      s_q  <= sum;
      c0_q <= cy;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      err_q <= 1'b0;
    end else if (red) begin
      x_q   <= y_q;
      y_q   <= res;
      err_q <= err_q | res_ge;
    end
  end

  assign busy_o = red;
  assign x_o    = x_q;
  assign y_o    = y_q;
  assign err_o  = err_q;

  assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (x_o == $past(y_o)));
  assert_no_double_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (red && c0_q && !err_q) |-> !cy);
  assert_err_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(busy_o));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !valid_i) |=> ($stable(x_o) && $stable(y_o)));
  assert_busy_ignores_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

endmodule

// File: tb/sim_mchk_accum.sv
`timescale 1ns/1ps
module sim_mchk_accum;
  localparam int W = 18;
  localparam int M = 254225;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         busy_o, err_o;
  logic [W-1:0] x_o, y_o;

  int vec_cnt = 0;
  int bad_cnt = 0;
  int rx = 0, ry = 0;
  bit rerr = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mchk_accum u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .busy_o (busy_o),
    .x_o    (x_o),
    .y_o    (y_o),
    .err_o  (err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      bad_cnt++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic ref_step(input int d);
    int s;
    s = rx + d;
    if (s >= M) s = s - M;
    rx = ry;
    ry = s;
    if (s >= M) rerr = 1'b1;
  endtask

  task automatic chk_state(input string req);
    chk(req, "x_o", int'(x_o), rx);
    chk(req, "y_o", int'(y_o), ry);
    chk(req, "err_o", int'(err_o), int'(rerr));
    chk(req, "busy_o", int'(busy_o), 0);
  endtask

  task automatic push(input int d, input string req);
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = W'(d);
    @(negedge clk_i);
    chk("R2", "busy_o", int'(busy_o), 1);
    valid_i = 1'b0;
    @(negedge clk_i);
    ref_step(d);
    chk_state(req);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    rx = 0; ry = 0; rerr = 1'b0;
    @(negedge clk_i);
    chk("R1", "x_o", int'(x_o), 0);
    chk("R1", "y_o", int'(y_o), 0);
    chk("R1", "busy_o", int'(busy_o), 0);
    chk("R1", "err_o", int'(err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_basic;
    push(100, "R4");
    push(200, "R4");
    push(5000, "R4");
    push(250000, "R4");
    push(123456, "R4");
  endtask

  task automatic t_exact;
    push(M - rx, "R6");
    chk("R6", "y_o zero", int'(y_o), 0);
    push(M - 1 - rx, "R6");
    chk("R6", "y_o max", int'(y_o), M - 1);
  endtask

  task automatic t_wrap;
    t_reset();
    push(254224, "R5");
    push(0, "R5");
    push(200000, "R5");
    chk("R5", "wrapped y_o", int'(y_o), 199999);
    push(262143 - 254225, "R5");
  endtask

  task automatic t_busy;
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = W'(10);
    @(negedge clk_i);
    chk("R2", "busy_o", int'(busy_o), 1);
    data_i = W'(77777);
    @(negedge clk_i);
    valid_i = 1'b0;
    ref_step(10);
    chk_state("R3");
    @(negedge clk_i);
    chk_state("R3");
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    data_i = W'(4242);
    repeat (4) @(negedge clk_i);
    chk_state("R10");
  endtask

  task automatic t_sweep;
    int v = 12345;
    for (int i = 0; i < 40; i++) begin
      v = (v * 1103 + 7919) % M;
      push(v, "R9");
    end
    chk("R9", "err_o after sweep", int'(err_o), 0);
  endtask

  task automatic t_err;
    t_reset();
    push(254224, "R9");
    push(0, "R9");
    push(254225, "R9");
    chk("R9", "y_o at M-1", int'(y_o), M - 1);
    chk("R9", "err_o at M-1", int'(err_o), 0);
    push(0, "R7");
    push(254226, "R7");
    chk("R7", "y_o at M", int'(y_o), M);
    chk("R7", "err_o at M", int'(err_o), 1);
    push(1, "R8");
    push(2, "R8");
    chk("R8", "err_o sticky", int'(err_o), 1);
    t_reset();
    chk("R1", "err_o cleared", int'(err_o), 0);
    push(254224, "R7");
    push(0, "R7");
    push(262143, "R7");
    chk("R7", "y_o far", int'(y_o), 262142);
    chk("R7", "err_o far", int'(err_o), 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad_cnt++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_exact();
    t_busy();
    t_idle();
    t_wrap();
    t_sweep();
    t_err();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule